// File: doc/BRIEF.md
# PLL Retune Sequencer

A hardware sequencer that moves a clock multiplier to a new ratio without software stepping through the update. A single-cycle request carries the desired multiplier. The block derives the divider, charge-pump, loop-resistor and lock-count fields from it and drives them onto the PLL control outputs. It then walks a fixed order: it forces bypass, pulses the PLL reset, waits for lock and finally releases bypass.

A bring-up flag on the request also clears the bypass qualifier together with forcing bypass, which is needed for first-time start-up. An out-of-range request is refused and changes nothing. If lock does not appear within a parameterised window, the sequence ends in error and bypass stays forced, so downstream logic keeps running on the reference clock.

Top module: `pll_retune_seq`

## Requirements
- R1: A request is accepted when `start_i` is high in idle and `mult_i` lies in 13..30. The divider output then equals the multiplier.
- R2: For an accepted request the charge-pump output is 2. The resistor output is 6 for multipliers 13..15, 10 for 16..19 and 12 for 20..30.
- R3: The lock-count output follows the multiplier: 13→750, 14→700, 15→650, 16→625, 17→575, 18→550, 19→525, 20→500, 21→475, 22→450, 23→425, 24..25→400, 26→375, 27..28→350, 29..30→325.
- R4: All config fields and `busy_o` are updated at the clock edge that samples the request, and bypass does not change at that edge. `byp_force_o` goes to 1 on the next edge.
- R5: `pll_rst_o` rises one edge after bypass is forced, while bypass is 1. It stays high for exactly RST_CYC cycles.
- R6: After reset release, the first cycle with `lock_i` high clears `byp_force_o`, pulses `done_o` for one cycle and drops `busy_o`, all at the same edge.
- R7: If `lock_i` is not seen within LOCK_TMO cycles after reset release, `err_o` is set and `busy_o` drops. `byp_force_o` stays 1 and `done_o` stays low.
- R8: Lock that arrives in the last cycle of the LOCK_TMO window counts as success. With the lock sampled at the m-th edge after reset release, the sequence succeeds exactly when m ≤ LOCK_TMO.
- R9: A request with `mult_i` outside 13..30 sets `err_o` at the next edge. Busy stays low and no PLL control output changes.
- R10: `byp_qual_o` resets to 1. A request with `init_i`=1 drives it to 0 at the same edge that forces bypass. A request with `init_i`=0 leaves it unchanged.
- R11: `start_i` is ignored while a sequence runs, so the config fields stay frozen until the sequence ends.
- R12: After reset, busy, done, error, bypass force, PLL reset and all config fields are 0, and the qualifier is 1.
- R13: `err_o` holds until the next accepted request, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| mult_i | input | MULT_W | Requested multiplier |
| init_i | input | 1 | Bring-up request: also clears the bypass qualifier |
| lock_i | input | 1 | PLL lock status |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse on successful completion |
| err_o | output | 1 | Rejected request or lock timeout |
| fdiv_o | output | 7 | Feedback divider field |
| cp_o | output | 4 | Charge-pump field |
| res_o | output | 4 | Loop-resistor field |
| lock_cnt_o | output | 10 | Lock-count field |
| byp_force_o | output | 1 | Bypass force control |
| byp_qual_o | output | 1 | Bypass qualifier control |
| pll_rst_o | output | 1 | PLL reset control |

## Verification
Lock detection and the lock-timeout expiry can fall on the same edge, and the design resolves this in favour of lock. The bench's PLL model raises lock a chosen number of cycles after reset release. The delay is set so that lock is first sampled exactly on the last edge of the window, and then one edge later. The first case must end in `done_o` with bypass released. The second must end in `err_o` with bypass still forced. Random delays on both sides of the boundary are judged against the same rule.

// File: rtl/pll_retune_pkg.sv
package pll_retune_pkg;

  localparam int unsigned FDIV_W = 7;
  localparam int unsigned CP_W   = 4;
  localparam int unsigned RES_W  = 4;
  localparam int unsigned LCNT_W = 10;

  typedef struct packed {
    logic [FDIV_W-1:0] fdiv;
    logic [CP_W-1:0]   cp;
    logic [RES_W-1:0]  res;
    logic [LCNT_W-1:0] lcnt;
  } pll_cfg_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BYP,
    ST_RST_ON,
    ST_RST_HOLD,
    ST_LOCK
  } seq_st_e;

  function automatic pll_cfg_t cfg_lookup(input logic [FDIV_W-1:0] m);
    pll_cfg_t c;
    c.fdiv = m;
    c.cp   = CP_W'(2);
    if (m <= 7'd15)      c.res = RES_W'(6);
    else if (m <= 7'd19) c.res = RES_W'(10);
    else                 c.res = RES_W'(12);
    case (m)
      7'd13:        c.lcnt = LCNT_W'(750);
      7'd14:        c.lcnt = LCNT_W'(700);
      7'd15:        c.lcnt = LCNT_W'(650);
      7'd16:        c.lcnt = LCNT_W'(625);
      7'd17:        c.lcnt = LCNT_W'(575);
      7'd18:        c.lcnt = LCNT_W'(550);
      7'd19:        c.lcnt = LCNT_W'(525);
      7'd20:        c.lcnt = LCNT_W'(500);
      7'd21:        c.lcnt = LCNT_W'(475);
      7'd22:        c.lcnt = LCNT_W'(450);
      7'd23:        c.lcnt = LCNT_W'(425);
      7'd24, 7'd25: c.lcnt = LCNT_W'(400);
      7'd26:        c.lcnt = LCNT_W'(375);
      7'd27, 7'd28: c.lcnt = LCNT_W'(350);
      7'd29, 7'd30: c.lcnt = LCNT_W'(325);
      default:      c.lcnt = '0;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pll_cfg_lut.sv
module pll_cfg_lut
  import pll_retune_pkg::*;
#(
  parameter int unsigned M_W  = 5,
  parameter int unsigned M_LO = 13,
  parameter int unsigned M_HI = 30
) (
  input  logic [M_W-1:0] mult_i,
  output logic           valid_o,
  output pll_cfg_t       cfg_o
);

  always_comb begin
    valid_o = (32'(mult_i) >= M_LO) && (32'(mult_i) <= M_HI);
    cfg_o   = valid_o ? cfg_lookup(FDIV_W'(mult_i)) : '0;
  end

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         dec_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/pll_retune_seq.sv
module pll_retune_seq
  import pll_retune_pkg::*;
#(
  parameter int unsigned MULT_W   = 5,
  parameter int unsigned RST_CYC  = 4,
  parameter int unsigned LOCK_TMO = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic              init_i,
  input  logic              lock_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [FDIV_W-1:0] fdiv_o,
  output logic [CP_W-1:0]   cp_o,
  output logic [RES_W-1:0]  res_o,
  output logic [LCNT_W-1:0] lock_cnt_o,
  output logic              byp_force_o,
  output logic              byp_qual_o,
  output logic              pll_rst_o
);

  localparam int unsigned TMR_MAX = (RST_CYC > LOCK_TMO) ? RST_CYC : LOCK_TMO;
  localparam int unsigned TMR_W   = $clog2(TMR_MAX + 1);

  seq_st_e    st_q;
  pll_cfg_t   cfg_q, req_cfg;
  logic       req_ok;
  logic       init_q, busy_q, done_q, err_q, byp_q, qual_q, prst_q;
  logic       tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0] tmr_val;

  pll_cfg_lut #(.M_W(MULT_W)) u_lut (
    .mult_i (mult_i),
    .valid_o(req_ok),
    .cfg_o  (req_cfg)
  );

  // one timer serves reset width and lock window; phases never overlap
  always_comb begin
    tmr_load = (st_q == ST_RST_ON) || (st_q == ST_RST_HOLD && tmr_zero);
    tmr_val  = (st_q == ST_RST_ON) ? TMR_W'(RST_CYC - 1) : TMR_W'(LOCK_TMO - 1);
    tmr_dec  = (st_q == ST_RST_HOLD) || (st_q == ST_LOCK);
  end

  pll_seq_timer #(.W(TMR_W)) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (tmr_load),
    .dec_i     (tmr_dec),
    .load_val_i(tmr_val),
    .zero_o    (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      init_q <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      byp_q  <= 1'b0;
      qual_q <= 1'b1;
      prst_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            if (req_ok) begin
              cfg_q  <= req_cfg;
              init_q <= init_i;
              err_q  <= 1'b0;
              busy_q <= 1'b1;
              st_q   <= ST_BYP;
            end else begin
              err_q  <= 1'b1;
            end
          end
        end
        ST_BYP: begin
          byp_q <= 1'b1;
          if (init_q) qual_q <= 1'b0;
          st_q  <= ST_RST_ON;
        end
        ST_RST_ON: begin
          prst_q <= 1'b1;
          st_q   <= ST_RST_HOLD;
        end
        ST_RST_HOLD: begin
          if (tmr_zero) begin
            prst_q <= 1'b0;
            st_q   <= ST_LOCK;
          end
        end
        ST_LOCK: begin
          // lock beats timeout on the same edge
          if (lock_i) begin
            byp_q  <= 1'b0;
            done_q <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end else if (tmr_zero) begin
            err_q  <= 1'b1;
            busy_q <= 1'b0;
            st_q   <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign fdiv_o      = cfg_q.fdiv;
  assign cp_o        = cfg_q.cp;
  assign res_o       = cfg_q.res;
  assign lock_cnt_o  = cfg_q.lcnt;
  assign byp_force_o = byp_q;
  assign byp_qual_o  = qual_q;
  assign pll_rst_o   = prst_q;

  assert_fields_before_bypass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(byp_force_o) |-> ($stable(fdiv_o) && $stable(lock_cnt_o) && busy_o));

  assert_reset_under_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pll_rst_o |-> byp_force_o);

  assert_done_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_after_lock_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(lock_i) && !byp_force_o && !busy_o));

  assert_timeout_keeps_bypass_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(err_o) && $past(busy_o)) |-> (byp_force_o && !done_o));

  assert_reject_no_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(err_o) && !$past(busy_o)) |-> (!busy_o && $stable(byp_force_o) && $stable(fdiv_o)));

  assert_fields_frozen_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(fdiv_o) && $stable(res_o) && $stable(lock_cnt_o)));

endmodule

// File: tb/pll_retune_seq_bench.sv
module pll_retune_seq_bench;
  localparam int RST_CYC = 4;
  localparam int TMO     = 40;

  logic clk = 1'b0;
  logic rst_n;
  logic start, init, lock;
  logic [4:0] mult;
  logic busy, done, err, byp, qual, prst;
  logic [6:0] fdiv;
  logic [3:0] cp, res;
  logic [9:0] lcnt;

  always #2 clk = ~clk;

  pll_retune_seq #(.MULT_W(5), .RST_CYC(RST_CYC), .LOCK_TMO(TMO)) u_pll_retune_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mult_i(mult), .init_i(init),
    .lock_i(lock), .busy_o(busy), .done_o(done), .err_o(err), .fdiv_o(fdiv),
    .cp_o(cp), .res_o(res), .lock_cnt_o(lcnt), .byp_force_o(byp),
    .byp_qual_o(qual), .pll_rst_o(prst)
  );

  // PLL model: lock drops in reset, returns lk_dly+1 edges after release
  int lk_dly = 0;
  bit lk_never = 1'b0;
  int lk_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock <= 1'b0; lk_cnt <= 0;
    end else if (prst) begin
      lock <= 1'b0; lk_cnt <= 0;
    end else if (!lock && !lk_never) begin
      if (lk_cnt >= lk_dly) lock <= 1'b1;
      else lk_cnt <= lk_cnt + 1;
    end
  end

  int n_chk = 0, n_fail = 0;
  bit exp_qual = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_res(input int m);
    if (m >= 20) return 12;
    if (m >= 16) return 10;
    return 6;
  endfunction

  function automatic int exp_lcnt(input int m);
    if (m >= 29) return 325;
    if (m >= 27) return 350;
    if (m == 26) return 375;
    if (m >= 24) return 400;
    if (m >= 20) return 500 - 25 * (m - 20);
    if (m == 16) return 625;
    if (m >= 17) return 575 - 25 * (m - 17);
    return 750 - 50 * (m - 13);
  endfunction

  task automatic run_seq(input int m, input bit ini, input int dly, input bit never, input bit poke);
    bit exp_ok;
    bit byp_prev;
    string tag;
    int w;
    int g;
    exp_ok = !never && (dly <= TMO - 2);
    tag = (!never && (dly == TMO - 2 || dly == TMO - 1)) ? "R8" : (exp_ok ? "R6" : "R7");
    lk_dly = dly; lk_never = never;
    @(negedge clk);
    start = 1'b1; mult = 5'(m); init = ini; byp_prev = byp;
    @(negedge clk);
    start = 1'b0; mult = 5'd0; init = 1'b0;
    chk(int'(fdiv) == m, "R1", int'(fdiv), m);
    chk(int'(cp) == 2, "R2", int'(cp), 2);
    chk(int'(res) == exp_res(m), "R2", int'(res), exp_res(m));
    chk(int'(lcnt) == exp_lcnt(m), "R3", int'(lcnt), exp_lcnt(m));
    chk(busy == 1'b1 && byp == byp_prev, "R4", int'(byp), int'(byp_prev));
    chk(err == 1'b0, "R13", int'(err), 0);
    @(negedge clk);
    chk(byp == 1'b1 && prst == 1'b0, "R4", int'(byp), 1);
    if (ini) exp_qual = 1'b0;
    chk(qual == exp_qual, "R10", int'(qual), int'(exp_qual));
    @(negedge clk);
    chk(prst == 1'b1, "R5", int'(prst), 1);
    w = 0;
    while (prst && w < 100) begin
      w++;
      if (poke && w == 1) begin start = 1'b1; mult = (m == 20) ? 5'd21 : 5'd20; end
      else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(w == RST_CYC, "R5", w, RST_CYC);
    g = 0;
    while (busy && g < TMO + 10) begin g++; @(negedge clk); end
    chk(done == exp_ok, tag, int'(done), int'(exp_ok));
    chk(err == !exp_ok, tag, int'(err), int'(!exp_ok));
    chk(byp == !exp_ok, tag, int'(byp), int'(!exp_ok));
    chk(int'(fdiv) == m, "R11", int'(fdiv), m);
    @(negedge clk);
    chk(done == 1'b0, "R6", int'(done), 0);
  endtask

  task automatic reject(input int m);
    logic [6:0] f0; logic [9:0] l0; logic b0, q0, r0;
    @(negedge clk);
    f0 = fdiv; l0 = lcnt; b0 = byp; q0 = qual; r0 = prst;
    start = 1'b1; mult = 5'(m);
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R9", int'(err), 1);
    repeat (3) @(negedge clk);
    chk(fdiv == f0 && lcnt == l0, "R9", int'(fdiv), int'(f0));
    chk(byp == b0 && qual == q0 && prst == r0 && busy == 1'b0, "R9", int'(byp), int'(b0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int r;
    r = $urandom(32'd1729);
    rst_n = 1'b0; start = 1'b0; init = 1'b0; mult = 5'd0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !err && !byp && !prst, "R12", int'(busy), 0);
    chk(qual == 1'b1 && fdiv == 7'd0 && lcnt == 10'd0, "R12", int'(qual), 1);
    rst_n = 1'b1;
    @(negedge clk);

    run_seq(13, 1'b1, 5, 1'b0, 1'b0);
    run_seq(30, 1'b0, TMO - 2, 1'b0, 1'b0);
    run_seq(24, 1'b0, TMO - 1, 1'b0, 1'b0);
    run_seq(16, 1'b0, 0, 1'b1, 1'b0);
    reject(12);
    reject(31);
    reject(0);
    run_seq(19, 1'b0, 2, 1'b0, 1'b1);
    for (int m = 13; m <= 30; m++) run_seq(m, 1'b0, m % 7, 1'b0, 1'b0);

    for (int i = 0; i < 40; i++) begin
      int m;
      if ($urandom % 7 == 0) begin
        m = ($urandom % 2 == 0) ? int'($urandom % 13) : 31;
        reject(m);
      end else begin
        m = 13 + int'($urandom % 18);
        run_seq(m, ($urandom % 9) == 0, int'($urandom % (TMO + 4)), 1'b0, ($urandom % 5) == 0);
      end
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule